// File: doc/BRIEF.md
# Serial DAC Write Frame Receiver

This block is the digital front end of a single-channel 16-bit voltage-output converter. A host writes to it over a three-wire serial link made of an active-low frame select, a serial clock and a data line. While the frame select is low, every falling edge of the serial clock shifts one data bit into a 24-bit input register. The word goes to the converter only after exactly 24 falling edges. Each such frame loads the 16-bit output code and the 2-bit power-down mode together.

All three serial pins are oversampled in the fast system clock domain. A chain of synchronizer flops feeds an edge detector, so the block needs no second clock domain. A frame that ends early is discarded, because the select rose before the last bit. Clock edges that come after the 24th edge are ignored until the select is raised and lowered again. At reset the code is zero and the mode is normal operation. A one-cycle strobe marks every load so that downstream analog control logic can follow it.

Top module: `dac_frame_rx`

## Requirements
- R1: After reset, `dac_code` is 0, `pd_mode` is 2'b00 (normal) and `update_stb` is low, and they hold those values until the first complete frame.
- R2: A frame is sent most significant bit first. Frame bits [15:0] are the straight-binary code, bits [17:16] are the power-down mode, and bits [23:18] have no effect.
- R3: The code and the mode change only in response to the 24th falling serial-clock edge of a frame. They take their new values SYNC_STAGES+2 system clock cycles after that edge reaches the pin.
- R4: If the frame select rises before the 24th falling edge (after as few as 10 or as many as 23 bits), the code and the mode keep their previous values and no strobe is raised.
- R5: Falling edges that arrive after the 24th edge while the select stays low shift nothing and change no output.
- R6: Data is sampled only on falling serial-clock edges. The value on the data line at a rising edge has no effect.
- R7: Mode encoding: 2'b00 is normal, 2'b01 is 1 k to ground, 2'b10 is 100 k to ground, 2'b11 is high impedance. A frame carrying 2'b00 leaves power-down and loads its code in the same update.
- R8: Lowering the select starts a new frame from bit zero, so bits left over from an aborted frame do not affect the next frame.
- R9: `update_stb` is high for exactly one system clock cycle for each complete frame. It rises in the same cycle in which the new code appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| sync_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdin | input | 1 | Serial data, most significant bit first |
| dac_code | output | 16 | Straight-binary code for the converter |
| pd_mode | output | 2 | Power-down mode (00 normal, 01 1 k, 10 100 k, 11 high impedance) |
| update_stb | output | 1 | One-cycle pulse when a new code and mode are loaded |

## Verification
The assertions check cycle-level rules on every cycle:
- the bit counter never moves without a detected falling edge while a frame is open;
- a completed frame needs a falling edge seen while the select was low;
- no completion happens after the 24th bit;
- the output register changes only when a load is requested;
- the strobe never lasts two cycles.

Only the bench scenarios can show the end-to-end properties. These are the bit order, the position of the code and mode fields, that a frame aborted at 10 or 23 bits leaves earlier values in place, that data on the rising edge is ignored, that a frame after an abort starts fresh, and the exact latency from the pin edge to the output.

// File: rtl/dac_frame_pkg.sv
package dac_frame_pkg;

   // Power-down mode carried in the frame; the bit pattern is decoded by the analog side
   typedef enum logic [1:0] {
      PD_NORMAL = 2'b00,
      PD_R1K    = 2'b01,
      PD_R100K  = 2'b10,
      PD_HIZ    = 2'b11
   } pd_mode_e;

   // Index of each serial pin inside the synchronizer bus
   localparam int unsigned PIN_SCLK = 2;
   localparam int unsigned PIN_SYNC = 1;
   localparam int unsigned PIN_DATA = 0;
   localparam int unsigned PIN_W    = 3;

endpackage

// File: rtl/dac_frame_sync.sv
module dac_frame_sync
   import dac_frame_pkg::*;
#(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic sync_n_i,
   input  logic sdin_i,
   output logic sclk_fall_o,
   output logic sync_hi_o,
   output logic sdin_o
);

   // Serial clock idles low, select idles high after reset
   localparam logic [PIN_W-1:0] RST_V = (PIN_W'(1) << PIN_SYNC);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dac_frame_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [PIN_W-1:0] chain [STAGES];
   logic [PIN_W-1:0] pins;
   logic             sclk_prev;

   assign pins[PIN_SCLK] = sclk_i;
   assign pins[PIN_SYNC] = sync_n_i;
   assign pins[PIN_DATA] = sdin_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST_V;
      else        chain[0] <= pins;
   end

   genvar g;
   generate
      for (g = 1; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RST_V;
            else        chain[g] <= chain[g-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= chain[STAGES-1][PIN_SCLK];
   end

   assign sclk_fall_o = sclk_prev & ~chain[STAGES-1][PIN_SCLK];
   assign sync_hi_o   = chain[STAGES-1][PIN_SYNC];
   assign sdin_o      = chain[STAGES-1][PIN_DATA];

   // R6: a detected fall is never followed directly by a second fall
   p_fall_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_fall_o |=> !sclk_fall_o);

endmodule

// File: rtl/dac_frame_shift.sv
module dac_frame_shift #(
   parameter int unsigned FRAME_BITS = 24
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sclk_fall,
   input  logic                  sync_hi,
   input  logic                  sdin,
   output logic                  frame_done,
   output logic [FRAME_BITS-1:0] frame_word
);

   localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

   generate
      if (FRAME_BITS < 2) begin : g_bad_frame
         $error("dac_frame_shift: FRAME_BITS must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0]      bit_cnt;
   logic [FRAME_BITS-1:0] shreg;
   logic                  take;

   assign take = sclk_fall && !sync_hi && (bit_cnt < FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt    <= '0;
         shreg      <= '0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         if (sync_hi) begin
            bit_cnt <= '0;
         end else if (take) begin
            shreg   <= {shreg[FRAME_BITS-2:0], sdin};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST) frame_done <= 1'b1;
         end
      end
   end

   assign frame_word = shreg;

   // R3: the counter never passes a full frame
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= FULL);

   // R6: without a falling edge inside an open frame, the counter holds
   p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclk_fall && !sync_hi) |=> $stable(bit_cnt));

   // R8: a raised select returns the counter to bit zero
   p_cnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sync_hi |=> (bit_cnt == '0));

   // R4: completion needs a falling edge while the select was low
   p_done_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> $past(sclk_fall && !sync_hi));

   // R5: a full frame does not complete a second time
   p_no_redo_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_cnt == FULL && !sync_hi) |=> !frame_done);

endmodule

// File: rtl/dac_frame_reg.sv
module dac_frame_reg #(
   parameter int unsigned CODE_W     = 16,
   parameter int unsigned MODE_W     = 2,
   parameter int unsigned FRAME_BITS = 24
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [FRAME_BITS-1:0] word,
   output logic [CODE_W-1:0]     code_o,
   output logic [MODE_W-1:0]     mode_o,
   output logic                  stb_o
);

   localparam int unsigned USED_W = CODE_W + MODE_W;
   localparam int unsigned PAD_W  = FRAME_BITS - USED_W;

   generate
      if (FRAME_BITS < USED_W) begin : g_bad_fit
         $error("dac_frame_reg: frame too short for code and mode");
      end
      if (PAD_W > 0) begin : g_pad
         logic [PAD_W-1:0] pad_unused;
         assign pad_unused = word[FRAME_BITS-1 -: PAD_W];
      end
   endgenerate

   logic [CODE_W-1:0] code_in;
   logic [MODE_W-1:0] mode_in;

   assign code_in = word[CODE_W-1:0];
   assign mode_in = word[USED_W-1:CODE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o <= '0;
         mode_o <= '0;
         stb_o  <= 1'b0;
      end else begin
         stb_o <= load;
         if (load) begin
            code_o <= code_in;
            mode_o <= mode_in;
         end
      end
   end

   // R4: outputs move only when a completed frame asks for it
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(code_o) && $stable(mode_o)));

   // R9: the strobe lasts a single cycle
   p_stb_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stb_o |=> !stb_o);

endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx #(
   parameter int unsigned CODE_W      = 16,
   parameter int unsigned MODE_W      = 2,
   parameter int unsigned FRAME_BITS  = 24,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_n,
   input  logic              sclk,
   input  logic              sdin,
   output logic [CODE_W-1:0] dac_code,
   output logic [MODE_W-1:0] pd_mode,
   output logic              update_stb
);

   logic                  sclk_fall;
   logic                  sync_hi;
   logic                  sdin_s;
   logic                  frame_done;
   logic [FRAME_BITS-1:0] frame_word;

   dac_frame_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk_i      (sclk),
      .sync_n_i    (sync_n),
      .sdin_i      (sdin),
      .sclk_fall_o (sclk_fall),
      .sync_hi_o   (sync_hi),
      .sdin_o      (sdin_s)
   );

   dac_frame_shift #(
      .FRAME_BITS (FRAME_BITS)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk_fall  (sclk_fall),
      .sync_hi    (sync_hi),
      .sdin       (sdin_s),
      .frame_done (frame_done),
      .frame_word (frame_word)
   );

   dac_frame_reg #(
      .CODE_W     (CODE_W),
      .MODE_W     (MODE_W),
      .FRAME_BITS (FRAME_BITS)
   ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (frame_done),
      .word   (frame_word),
      .code_o (dac_code),
      .mode_o (pd_mode),
      .stb_o  (update_stb)
   );

   // R9: a strobe is always preceded by a completed frame
   p_stb_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      update_stb |-> $past(frame_done));

endmodule

// File: tb/dac_frame_rx_tb.sv
module dac_frame_rx_tb;

   localparam int H   = 4;   // system cycles per serial half-phase
   localparam int LAT = 4;   // SYNC_STAGES + 2

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_n = 1'b1;
   logic sclk = 1'b0;
   logic sdin = 1'b0;
   logic [15:0] dac_code;
   logic [1:0]  pd_mode;
   logic        update_stb;

   int n_chk = 0;
   int n_fail = 0;

   // reference model state
   int          m_cnt = 0;
   logic [23:0] m_word = '0;
   logic [23:0] pend = '0;
   int          cd = 0;
   logic [15:0] exp_code = '0;
   logic [1:0]  exp_mode = '0;
   logic        exp_stb = 1'b0;
   int          frames_done = 0;
   int          stb_seen = 0;

   always #10 clk = ~clk;

   dac_frame_rx u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_n     (sync_n),
      .sclk       (sclk),
      .sdin       (sdin),
      .dac_code   (dac_code),
      .pd_mode    (pd_mode),
      .update_stb (update_stb)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // model reaction to a falling serial-clock edge at the pin
   task automatic model_fall(input logic b);
      if (m_cnt < 24) begin
         m_word = {m_word[22:0], b};
         m_cnt++;
         if (m_cnt == 24) begin
            pend = m_word;
            cd = LAT;
            frames_done++;
         end
      end
   endtask

   always @(posedge clk) begin
      exp_stb = 1'b0;
      if (cd > 0) begin
         cd--;
         if (cd == 0) begin
            exp_code = pend[15:0];
            exp_mode = pend[17:16];
            exp_stb  = 1'b1;
         end
      end
   end

   // per-cycle comparison against the model (R3 timing, R9 strobe)
   always @(negedge clk) begin
      if (rst_n) begin
         check(dac_code == exp_code, "R3 code", 32'(dac_code), 32'(exp_code));
         check(pd_mode == exp_mode, "R3 mode", 32'(pd_mode), 32'(exp_mode));
         check(update_stb == exp_stb, "R9 strobe", 32'(update_stb), 32'(exp_stb));
         if (update_stb) stb_seen++;
      end
   end

   // send nbits; bits past 24 are inverted copies so a wrong shift shows
   task automatic frame(input logic [23:0] w, input int nbits);
      sync_n = 1'b0;
      wait_cyc(H);
      for (int i = 0; i < nbits; i++) begin
         logic b;
         b = (i < 24) ? w[23-i] : ~w[23-(i%24)];
         sdin = ~b;          // wrong value on the rising edge (R6)
         sclk = 1'b1;
         wait_cyc(H);
         sdin = b;
         wait_cyc(H);
         sclk = 1'b0;
         model_fall(b);
         wait_cyc(H);
      end
      sync_n = 1'b1;
      m_cnt = 0;
      wait_cyc(3 * H);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
   end

   initial begin
      wait_cyc(3);
      check(dac_code == 16'h0, "R1 code", 32'(dac_code), 32'h0);
      check(pd_mode == 2'b00, "R1 mode", 32'(pd_mode), 32'h0);
      check(update_stb == 1'b0, "R1 strobe", 32'(update_stb), 32'h0);
      rst_n = 1'b1;
      wait_cyc(10);
      check(dac_code == 16'h0 && pd_mode == 2'b00, "R1 idle", 32'(dac_code), 32'h0);

      // R2: top pad bits all ones, normal mode
      frame({6'h3F, 2'b00, 16'hA5C3}, 24);
      check(dac_code == 16'hA5C3, "R2 code field", 32'(dac_code), 32'hA5C3);
      check(pd_mode == 2'b00, "R2 pad ignored", 32'(pd_mode), 32'h0);
      check(dac_code == 16'hA5C3, "R6 rising data ignored", 32'(dac_code), 32'hA5C3);

      // R7: high impedance mode
      frame({6'h00, 2'b11, 16'h1234}, 24);
      check(pd_mode == 2'b11, "R7 hiz", 32'(pd_mode), 32'h3);
      check(dac_code == 16'h1234, "R7 code", 32'(dac_code), 32'h1234);

      // R4: abort after 10 bits
      frame({6'h15, 2'b01, 16'hFFFF}, 10);
      check(dac_code == 16'h1234, "R4 abort10 code", 32'(dac_code), 32'h1234);
      check(pd_mode == 2'b11, "R4 abort10 mode", 32'(pd_mode), 32'h3);

      // R8: fresh frame after abort
      frame({6'h2A, 2'b10, 16'h0F0F}, 24);
      check(dac_code == 16'h0F0F, "R8 fresh code", 32'(dac_code), 32'h0F0F);
      check(pd_mode == 2'b10, "R8 mode 100k", 32'(pd_mode), 32'h2);

      // R5: extra edges after the 24th
      frame({6'h01, 2'b01, 16'h8001}, 30);
      check(dac_code == 16'h8001, "R5 extra edges code", 32'(dac_code), 32'h8001);
      check(pd_mode == 2'b01, "R5 extra edges mode", 32'(pd_mode), 32'h1);

      // R4: abort at 23 bits, boundary
      frame({6'h00, 2'b00, 16'h5555}, 23);
      check(dac_code == 16'h8001, "R4 abort23 code", 32'(dac_code), 32'h8001);
      check(pd_mode == 2'b01, "R4 abort23 mode", 32'(pd_mode), 32'h1);

      // R7: normal mode write leaves power-down with new code
      frame({6'h00, 2'b00, 16'h7777}, 24);
      check(pd_mode == 2'b00, "R7 back to normal", 32'(pd_mode), 32'h0);
      check(dac_code == 16'h7777, "R7 code with normal", 32'(dac_code), 32'h7777);

      // R9: one strobe per complete frame
      check(stb_seen == frames_done, "R9 strobe count", 32'(stb_seen), 32'(frames_done));
      check(frames_done == 5, "R9 frame count", 32'(frames_done), 32'd5);

      summary();
   end

endmodule